// File: doc/BRIEF.md
# Trigger Message Generator

This block produces one 32-bit trigger message for every trigger it accepts. Triggers arrive on two single-cycle strobes: a software strobe from inside the chip and a trigger input from outside. Each message joins a per-event options word, which software may rewrite before any event, with a run-level seed. The seed holds a starting event number, a two-bit tag and a parity sense, and is captured only when a latch bit in the configuration word rises. A running 17-bit count, with the tag as its two top bits, advances once per message and wraps to zero.

Externally caused messages obey a readout rule. When the options word asks for plain readout on external triggers, the calibration-strobe and acknowledge bits of such messages are forced low. This lets software fire a bare strobe from the software trigger and have the resulting external trigger come back as an ordinary readout. Messages leave the block as a one-cycle valid pulse together with the data. The output takes no back-pressure: the consumer must take each message in the cycle in which `msg_valid` is high. When both strobes fire together, or when externals arrive while software triggers are being served, external requests wait in a small pending counter.

Top module: `trig_msg_gen`

## Requirements
- R1: After reset `msg_valid` is 0, `msg_data` is 0, the count is 0, the parity sense is odd and no external request is pending. A trigger before any latch therefore yields event 0, tag 0.
- R2: The seed is captured only in a cycle where `cfg_word[19]` is 1 and was 0 in the previous cycle (its previous value is 0 after reset). The event number is taken from `cfg_word[14:0]`, the tag from `cfg_word[16:15]` and the parity sense from `cfg_word[17]`. Changes to `cfg_word[17:0]` while bit 19 stays high have no effect.
- R3: The first message after a capture carries the seed. Each later message carries a count one higher than the message before it.
- R4: The 17-bit count {tag, event} wraps from all ones (tag 3, event 0x7FFF) to zero.
- R5: Bit 15 of the message is the parity bit. It makes the number of ones in all 32 bits even when the sense is 1 and odd when the sense is 0.
- R6: Layout: `msg_data[14:0]` is the event number, `msg_data[17:16]` is the tag and `msg_data[31:18]` is `opt_word[15:2]`. `opt_word[1:0]` are ignored. Options are sampled in the cycle the message is issued.
- R7: For an externally caused message with `opt_word[13]` (plain-readout flag) set, `msg_data[31]` (calibration strobe, from `opt_word[15]`) and `msg_data[30]` (acknowledge, from `opt_word[14]`) are 0.
- R8: A software-caused message, or an external one with `opt_word[13]` clear, copies `opt_word[15:14]` into `msg_data[31:30]`.
- R9: When both strobes are high in one cycle, the software message is issued first. The external one follows in the next cycle unless a further software strobe takes that cycle.
- R10: A message appears as `msg_valid` high for one cycle, in the cycle after the strobe that issues it, one per issued trigger. No message appears without a trigger.
- R11: External requests not served at once are held in a counter of up to 2^PEND_W-1 (7 by default) and are served one per cycle whenever the software strobe is low. Requests beyond that count are dropped.
- R12: When a capture coincides with an issued message, that message uses the count and sense from before the capture, and the next message uses the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 20 | Run configuration: seed fields [17:0], latch bit [19] |
| opt_word | input | 16 | Per-event options word |
| sw_trig | input | 1 | Software trigger strobe, one trigger per high cycle |
| ext_trig | input | 1 | External trigger strobe, one trigger per high cycle |
| msg_valid | output | 1 | One-cycle pulse marking a new message |
| msg_data | output | 32 | Trigger message |

## Verification
The hardest state to reach from the ports is a full pending counter. External requests only pile up while the software strobe wins every cycle. The stimulus therefore holds both strobes high for longer than the counter depth, so that later requests are dropped. It then releases them and counts exactly seven external messages, followed by silence. A capture landing in the same cycle as an issued message is also set up on purpose: the latch bit is raised in the same cycle as a software strobe.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  localparam int EVT_W   = 15;
  localparam int TAG_W   = 2;
  localparam int CNT_W   = EVT_W + TAG_W;
  localparam int MSG_W   = 32;
  localparam int OPT_W   = 16;
  localparam int CFG_W   = 20;
  localparam int OPT_LO  = TAG_W;          // options bits below this are dropped
  localparam int SENSE_BIT = CNT_W;        // parity sense position in cfg
  localparam int LATCH_BIT = 19;           // capture control position in cfg
  localparam int OPT_STB = 15;             // calibration strobe
  localparam int OPT_ACK = 14;             // trigger acknowledge
  localparam int OPT_XRO = 13;             // plain readout on external triggers
  localparam int PAR_BIT = EVT_W;          // parity position in message

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [EVT_W-1:0] evt;
  } count_t;
endpackage

// File: rtl/tmg_seed_latch.sv
module tmg_seed_latch
  import tmg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_bit,
  input  logic             sense_in,
  output logic             load,
  output logic             sense_q
);
  logic latch_prev;

  assign load = latch_bit & ~latch_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_prev <= 1'b0;
      sense_q    <= 1'b0;
    end else begin
      latch_prev <= latch_bit;
      if (load) sense_q <= sense_in;
    end
  end
endmodule

// File: rtl/tmg_event_ctr.sv
module tmg_event_ctr
  import tmg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  count_t seed,
  input  logic   step,
  output count_t count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= seed;
    else if (step) count <= count + ONE;   // natural wrap at all ones
  end
endmodule

// File: rtl/tmg_trig_arb.sv
module tmg_trig_arb
  import tmg_pkg::*;
#(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_trig,
  input  logic              ext_trig,
  output src_e              src,
  output logic [PEND_W-1:0] pend_cnt
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] ONE_P    = PEND_W'(1);

  logic take_ext;

  always_comb begin
    if (sw_trig)                           src = SRC_SW;
    else if (ext_trig || pend_cnt != '0)   src = SRC_EXT;
    else                                   src = SRC_NONE;
  end

  assign take_ext = (src == SRC_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
    end else if (ext_trig && !take_ext) begin
      if (pend_cnt != PEND_MAX) pend_cnt <= pend_cnt + ONE_P;
    end else if (!ext_trig && take_ext) begin
      pend_cnt <= pend_cnt - ONE_P;
    end
  end
endmodule

// File: rtl/tmg_msg_build.sv
module tmg_msg_build
  import tmg_pkg::*;
(
  input  src_e                   src,
  input  count_t                 count,
  input  logic                   sense,
  input  logic [OPT_W-1:OPT_LO]  opt_hi,
  output logic [MSG_W-1:0]       msg
);
  logic [OPT_W-1:OPT_LO] hi;
  logic                  strip;
  logic [MSG_W-1:0]      body;
  logic                  odd_ones;

  assign strip = (src == SRC_EXT) && opt_hi[OPT_XRO];

  for (genvar i = OPT_LO; i < OPT_W; i++) begin : g_opt
    if (i == OPT_STB || i == OPT_ACK) begin : g_masked
      assign hi[i] = opt_hi[i] & ~strip;
    end else begin : g_plain
      assign hi[i] = opt_hi[i];
    end
  end

  assign body     = {hi, count.tag, 1'b0, count.evt};
  assign odd_ones = ^body;

  always_comb begin
    msg          = body;
    // sense 1: total even, so parity copies odd_ones; sense 0: total odd
    msg[PAR_BIT] = sense ? odd_ones : ~odd_ones;
  end
endmodule

// File: rtl/trig_msg_gen.sv
module trig_msg_gen
  import tmg_pkg::*;
#(
  parameter int PEND_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [OPT_W-1:0] opt_word,
  input  logic             sw_trig,
  input  logic             ext_trig,
  output logic             msg_valid,
  output logic [MSG_W-1:0] msg_data
);
  logic              seed_load;
  logic              sense_q;
  count_t            cnt_q;
  count_t            seed;
  src_e              src;
  logic [PEND_W-1:0] pend_cnt;
  logic              issue;
  logic [MSG_W-1:0]  msg_next;
  logic [2:0]        unused_bits;

  assign unused_bits = {cfg_word[18], opt_word[1:0]};
  assign seed        = count_t'(cfg_word[CNT_W-1:0]);
  assign issue       = (src != SRC_NONE);

  tmg_seed_latch u_seed (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_bit (cfg_word[LATCH_BIT]),
    .sense_in  (cfg_word[SENSE_BIT]),
    .load      (seed_load),
    .sense_q   (sense_q)
  );

  tmg_event_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed),
    .step  (issue),
    .count (cnt_q)
  );

  tmg_trig_arb #(.PEND_W(PEND_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_trig  (sw_trig),
    .ext_trig (ext_trig),
    .src      (src),
    .pend_cnt (pend_cnt)
  );

  tmg_msg_build u_build (
    .src    (src),
    .count  (cnt_q),
    .sense  (sense_q),
    .opt_hi (opt_word[OPT_W-1:OPT_LO]),
    .msg    (msg_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
    end else begin
      msg_valid <= issue;
      if (issue) msg_data <= msg_next;
    end
  end
endmodule

// File: rtl/tmg_checker.sv
module tmg_checker
  import tmg_pkg::*;
#(
  parameter int PEND_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SENSE_BIT:0]    cfg_low,
  input logic [OPT_W-1:OPT_LO] opt_hi,
  input logic                  sw_trig,
  input logic                  ext_trig,
  input logic                  msg_valid,
  input logic [MSG_W-1:0]      msg_data,
  input logic [CNT_W-1:0]      count,
  input logic                  sense_q,
  input logic                  load,
  input logic                  issue,
  input logic [PEND_W-1:0]     pend_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             armed;
  logic [CNT_W-1:0] prev_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      prev_count <= '0;
    end else begin
      armed      <= 1'b1;
      prev_count <= count;
    end
  end

  assert_seed_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(load) |-> count == $past(cfg_low[CNT_W-1:0]) && sense_q == $past(cfg_low[SENSE_BIT]));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(issue && !load) |-> count == prev_count + ONE);

  assert_parity_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && msg_valid |-> (^msg_data) == !$past(sense_q));

  assert_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && msg_valid |-> msg_data[28:18] == $past(opt_hi[12:2]) && msg_data[14:0] == $past(count[EVT_W-1:0]));

  assert_ext_strip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && msg_valid && !$past(sw_trig) && $past(opt_hi[OPT_XRO]) |-> msg_data[31:30] == 2'b00);

  assert_sw_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && msg_valid && $past(sw_trig) |-> msg_data[31:30] == $past(opt_hi[OPT_STB:OPT_ACK]));

  assert_both_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig && ext_trig |=> pend_cnt != '0);

  assert_valid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && msg_valid |-> $past(sw_trig || ext_trig || pend_cnt != '0));
endmodule

bind trig_msg_gen tmg_checker #(.PEND_W(PEND_W)) u_tmg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_low   (cfg_word[tmg_pkg::SENSE_BIT:0]),
  .opt_hi    (opt_word[tmg_pkg::OPT_W-1:tmg_pkg::OPT_LO]),
  .sw_trig   (sw_trig),
  .ext_trig  (ext_trig),
  .msg_valid (msg_valid),
  .msg_data  (msg_data),
  .count     (cnt_q),
  .sense_q   (sense_q),
  .load      (seed_load),
  .issue     (issue),
  .pend_cnt  (pend_cnt)
);

// File: tb/test_trig_msg_gen.sv
`timescale 1ns/1ps
module test_trig_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cfg_word = '0;
  logic [15:0] opt_word = '0;
  logic        sw_trig = 1'b0;
  logic        ext_trig = 1'b0;
  logic        msg_valid;
  logic [31:0] msg_data;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state, kept from the requirements
  logic [16:0] m_cnt   = '0;
  logic        m_sense = 1'b0;
  int          m_pend  = 0;
  logic        m_prev  = 1'b0;

  // {sw, ext, opt[15:0]}
  localparam logic [17:0] VEC [0:11] = '{
    18'h2E004, 18'h1E004, 18'h1C004, 18'h00000,
    18'h3A5FC, 18'h0A5FC, 18'h16000, 18'h20003,
    18'h1FFFF, 18'h00000, 18'h24000, 18'h18000
  };

  always #4 clk = ~clk;   // 125 MHz

  trig_msg_gen i_trig_msg_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .opt_word  (opt_word),
    .sw_trig   (sw_trig),
    .ext_trig  (ext_trig),
    .msg_valid (msg_valid),
    .msg_data  (msg_data)
  );

  function automatic logic [31:0] ref_msg(input logic [16:0] cnt, input logic sense,
                                          input logic [15:0] opt, input logic is_ext);
    logic [31:0] m;
    m = '0;
    m[31:18] = opt[15:2];
    if (is_ext && opt[13]) m[31:30] = 2'b00;
    m[17:16] = cnt[16:15];
    m[14:0]  = cnt[14:0];
    if (sense) m[15] = ($countones(m) % 2) == 1;   // make total even
    else       m[15] = ($countones(m) % 2) == 0;   // make total odd
    return m;
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic step(input logic sw, input logic ext, input logic [15:0] opt,
                      input logic [19:0] cfg, input string rq);
    logic        e_valid;
    logic        is_ext;
    logic [31:0] e_data;
    logic        rise;
    sw_trig  = sw;
    ext_trig = ext;
    opt_word = opt;
    cfg_word = cfg;
    is_ext  = !sw && (ext || m_pend > 0);
    e_valid = sw || is_ext;
    e_data  = ref_msg(m_cnt, m_sense, opt, is_ext);
    if (ext && !is_ext) begin
      if (m_pend < 7) m_pend++;
    end else if (!ext && is_ext) m_pend--;
    rise   = cfg[19] && !m_prev;
    m_prev = cfg[19];
    if (rise) begin
      m_cnt   = cfg[16:0];
      m_sense = cfg[17];
    end else if (e_valid) m_cnt = m_cnt + 17'd1;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (msg_valid !== e_valid || (e_valid && msg_data !== e_data)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%08h expected valid=%0b data=%08h",
               rq, msg_valid, msg_data, e_valid, e_data);
    end
  endtask

  initial begin : watchdog
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog: valid=%0b data=%08h expected run to finish", msg_valid, msg_data);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [19:0] cfg_a;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (msg_valid !== 1'b0 || msg_data !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: valid=%0b data=%08h expected valid=0 data=00000000", msg_valid, msg_data);
    end
    rst_n = 1'b1;
    step(1'b0, 1'b0, 16'h0000, 20'h0, "R1 idle");
    step(1'b1, 1'b0, 16'h4004, 20'h0, "R1 first message");
    // R2: capture seed tag 1, event 0x1234, even sense
    cfg_a = 20'h80000 | 20'h20000 | 20'h08000 | 20'h01234;
    step(1'b0, 1'b0, 16'h0000, cfg_a, "R2 capture");
    step(1'b1, 1'b0, 16'h0000, cfg_a ^ 20'h2ABCD, "R2 held bit ignored");
    step(1'b1, 1'b0, 16'h0000, cfg_a ^ 20'h2ABCD, "R3 increment");
    // table of R6/R7/R8/R9 patterns
    for (int k = 0; k < 12; k++)
      step(VEC[k][17], VEC[k][16], VEC[k][15:0], cfg_a, "R6/R7/R8 table");
    // R4: wrap, odd sense
    step(1'b0, 1'b0, 16'h0000, 20'h00000, "R4 drop latch");
    step(1'b0, 1'b0, 16'h0000, 20'h9FFFF & 20'hDFFFF | 20'h1FFFF, "R4 capture all ones");
    step(1'b1, 1'b0, 16'h2000, 20'h9FFFF, "R4 max count");
    step(1'b1, 1'b0, 16'h2000, 20'h9FFFF, "R4 wrapped");
    step(1'b1, 1'b0, 16'hC000, 20'h9FFFF, "R5 odd sense");
    // R12: capture coincides with a message
    step(1'b0, 1'b0, 16'h0000, 20'h00000, "R12 drop latch");
    step(1'b1, 1'b0, 16'h8000, 20'hA0100, "R12 old count used");
    step(1'b1, 1'b0, 16'h8000, 20'hA0100, "R12 seed next");
    // R9: coincident strobes
    step(1'b1, 1'b1, 16'hE000, 20'hA0100, "R9 software first");
    step(1'b0, 1'b0, 16'hE000, 20'hA0100, "R9 external next");
    step(1'b0, 1'b0, 16'hE000, 20'hA0100, "R10 quiet");
    // R11: saturate pending externals, then drain
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 16'h4000, 20'hA0100, "R11 fill");
    for (int k = 0; k < 9; k++)  step(1'b0, 1'b0, 16'hC000, 20'hA0100, "R11 drain");
    step(1'b0, 1'b1, 16'hE000, 20'hA0100, "R7 direct external");
    step(1'b0, 1'b0, 16'h0000, 20'hA0100, "R10 no trigger");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule